// File: doc/BRIEF.md
# Counter Clock and Gate Router

This block sits in front of a ring of three-channel counter units and decides, for every counter channel, which signal advances the counter and which signal gates it. Each channel has a clock-select field and a gate-select field, written over a simple write-only register bus. From these fields the block steers one of several candidates onto a per-channel clock-enable pulse and a per-channel gate level. The candidates are the channel's own clock and gate pins, a per-unit external clock pin, internally divided rates, outputs of neighbouring channels in the ring, and signals derived from a pattern-present input.

The block contains the rate divider that turns the 20 MHz system clock into single-cycle ticks at 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz. It also contains a pair of pattern-event latches. One marks that the pattern has been seen. The other marks that the pattern has gone away after being seen. For each channel it also drives direction controls for the clock and gate pins, which become outputs whenever they are not selected as that channel's source. All pin, counter-output and pattern inputs are taken to be synchronous to the system clock. The counters themselves live outside this block.

Top module: `ctr_clkgate_router`

## Requirements
- R1: After reset every clock select and gate select is 0, enhanced mode is off, the occurred latch is low and the gone-away latch is high, so each gate is high, no clock enable is asserted, every clock pin is an input and every gate pin is an output.
- R2: Clock code 0 gives an enable pulse one cycle after a rising edge on the channel's own clock pin. Clock code 7 does the same for the external clock pin of the channel's own unit only.
- R3: Clock codes 1 to 5 give one-cycle enables every 2, 20, 200, 2000 and 20000 system cycles. In enhanced mode, code 11 gives an enable every cycle.
- R4: Clock code 6 pulses on a rising edge of the preceding channel's output. For channel n>0 of a unit this is channel n-1 of that unit. For channel 0 it is channel 2 of the preceding unit, and the highest unit precedes unit 0.
- R5: Gate code 0 is high, 1 is low, 2 follows the gate pin, and 3 is the inverted output of the "n-2" channel. For channel 2 that is channel 0 of the same unit; for channels 0 and 1 it is channel n+1 of the preceding unit in the ring.
- R6: In enhanced mode, gate code 6 is the inverted gate pin and gate code 7 the true "n-2" output. Clock codes 8 (constant high) and 9 (constant low) never produce an enable. Clock code 10 pulses on a rising edge of pattern-present.
- R7: In enhanced mode, gate codes 8, 9 and 10 give pattern-present, the occurred latch and the gone-away latch, and codes 11, 12 and 13 give their inverses. The occurred latch sets when the pattern is present. The gone-away latch clears when the pattern is absent after it has occurred. Both latches hold until re-armed.
- R8: A control write with bit 1 set re-arms the pattern logic, returning occurred to low and gone-away to high.
- R9: Control bit 0 selects enhanced mode. With it off, a select write stores only the low 3 bits of the data, so a written 9 acts as code 1 and a written 8 acts as code 0.
- R10: Reserved codes force the selected signal low. Without enhanced mode these are gate codes 4 to 7. With enhanced mode they are gate codes 4, 5 and 14 to 31, and clock codes 12 to 31 give no enable.
- R11: A channel's clock-pin direction output is high exactly when its clock select is not 0. Its gate-pin direction output is high exactly when its gate select is not 2. Both reflect a write from the cycle after it.
- R12: Channel c's clock select is at address 2c, its gate select at 2c+1, and the control register at address 2 x (channel count). Writes to higher addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | SEL_W | Register write data |
| clk_pin | input | NCH | Per-channel clock pin level |
| gat_pin | input | NCH | Per-channel gate pin level |
| ext_clk | input | NUM_UNITS | Per-unit shared external clock pin level |
| cnt_out | input | NCH | Output of every counter channel |
| pattern_present | input | 1 | Pattern-present level |
| cnt_clk_en | output | NCH | Per-channel one-cycle clock enable |
| cnt_gate | output | NCH | Per-channel gate level |
| clk_pin_oe | output | NCH | High when the channel's clock pin is driven as an output |
| gat_pin_oe | output | NCH | High when the channel's gate pin is driven as an output |
| pat_occurred | output | 1 | Latched pattern-occurred signal |
| pat_gone | output | 1 | Latched pattern-gone-away signal (active low) |

## Verification
A select write is captured at the clock edge that samples the strobe. The direction outputs are combinational from the stored field, so they are checked at the next falling edge. The gate and clock-enable outputs are registered one stage past the select mux, so gate levels after a write are read one further falling edge later. An enable produced by a rising edge on a pin, counter output or pattern input is checked high at the first falling edge after the edge that samples it and low at the next one. The pattern latches add one register ahead of the gate mux, so latch-driven gates are read two falling edges after the pattern input changes. Divided rates are checked by counting falling edges between consecutive enables, which removes any dependence on divider phase.

// File: rtl/cgr_pkg.sv
package cgr_pkg;
  localparam int CH_PER_UNIT = 3;
  localparam int BASIC_W     = 3;
  localparam int NUM_RATES   = 5;

  // clock select codes
  localparam int CK_PIN  = 0;
  localparam int CK_PREV = 6;
  localparam int CK_EXT  = 7;
  localparam int CK_HIGH = 8;
  localparam int CK_LOW  = 9;
  localparam int CK_PAT  = 10;
  localparam int CK_FAST = 11;

  // gate select codes
  localparam int GT_ON       = 0;
  localparam int GT_OFF      = 1;
  localparam int GT_PIN      = 2;
  localparam int GT_NM2_INV  = 3;
  localparam int GT_PIN_INV  = 6;
  localparam int GT_NM2      = 7;
  localparam int GT_PAT      = 8;
  localparam int GT_OCC      = 9;
  localparam int GT_GONE     = 10;
  localparam int GT_PAT_INV  = 11;
  localparam int GT_OCC_INV  = 12;
  localparam int GT_GONE_INV = 13;

  function automatic int prev_unit(input int u, input int nu);
    return (u + nu - 1) % nu;
  endfunction

  // source channel for the "preceding output" clock
  function automatic int prev_clk_idx(input int u, input int c, input int nu);
    if (c == 0) return prev_unit(u, nu) * CH_PER_UNIT + 2;
    return u * CH_PER_UNIT + c - 1;
  endfunction

  // source channel for the "n-2" gate
  function automatic int nm2_idx(input int u, input int c, input int nu);
    if (c == 2) return u * CH_PER_UNIT;
    return prev_unit(u, nu) * CH_PER_UNIT + c + 1;
  endfunction
endpackage

// File: rtl/cgr_tick_gen.sv
module cgr_tick_gen #(
  parameter int FIRST_DIV = 2,
  parameter int DECADE    = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic [cgr_pkg::NUM_RATES:0]  tick_o
);
  import cgr_pkg::*;

  localparam int W0    = (FIRST_DIV > 1) ? $clog2(FIRST_DIV) : 1;
  localparam int WD    = $clog2(DECADE);
  localparam int NDEC  = NUM_RATES - 1;
  localparam logic [W0-1:0] LAST0 = W0'(FIRST_DIV - 1);
  localparam logic [WD-1:0] LASTD = WD'(DECADE - 1);

  logic [W0-1:0] pre_q, pre_nxt;

  always_comb begin
    pre_nxt = (pre_q == LAST0) ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_nxt;
  end

  assign tick_o[0] = 1'b1;
  assign tick_o[1] = (pre_q == LAST0);

  for (genvar k = 0; k < NDEC; k++) begin : g_dec
    logic [WD-1:0] dcnt_q, dcnt_nxt;
    logic          adv;

    assign adv = tick_o[k+1];

    always_comb begin
      dcnt_nxt = dcnt_q;
      if (adv) dcnt_nxt = (dcnt_q == LASTD) ? '0 : dcnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dcnt_q <= '0;
      else        dcnt_q <= dcnt_nxt;
    end

    assign tick_o[k+2] = adv && (dcnt_q == LASTD);

    // R3
    tick_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o[k+2] |-> tick_o[k+1]);
  end
endmodule

// File: rtl/cgr_pattern_latch.sv
module cgr_pattern_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pat_i,
  input  logic rearm_i,
  output logic occ_o,
  output logic gone_o
);
  logic occ_q, occ_nxt;
  logic gone_q, gone_nxt;

  always_comb begin
    if (rearm_i) begin
      occ_nxt  = 1'b0;
      gone_nxt = 1'b1;
    end else begin
      occ_nxt  = occ_q | pat_i;
      gone_nxt = gone_q & ~(occ_q & ~pat_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= 1'b0;
      gone_q <= 1'b1;
    end else begin
      occ_q  <= occ_nxt;
      gone_q <= gone_nxt;
    end
  end

  assign occ_o  = occ_q;
  assign gone_o = gone_q;

  // R7
  occ_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q && !rearm_i) |=> occ_q);
  // R7
  gone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gone_q && !rearm_i) |=> !gone_q);
  // R7
  gone_after_occ_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gone_q) |-> $past(occ_q));
  // R8
  rearm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i |=> (!occ_q && gone_q));
endmodule

// File: rtl/cgr_sel_regs.sv
module cgr_sel_regs #(
  parameter int NCH    = 6,
  parameter int SEL_W  = 5,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [SEL_W-1:0]           wdata_i,
  output logic [NCH-1:0][SEL_W-1:0]  csel_o,
  output logic [NCH-1:0][SEL_W-1:0]  gsel_o,
  output logic                       enh_o,
  output logic                       rearm_o
);
  import cgr_pkg::*;

  localparam int CTRL_ADDR = 2 * NCH;

  logic [NCH-1:0][SEL_W-1:0] csel_q, csel_nxt;
  logic [NCH-1:0][SEL_W-1:0] gsel_q, gsel_nxt;
  logic                      enh_q, enh_nxt;
  logic [SEL_W-1:0]          store_val;
  logic                      ctrl_we;
  logic [NCH-1:0]            we_clk, we_gate;

  always_comb begin
    store_val = enh_q ? wdata_i : {{(SEL_W-BASIC_W){1'b0}}, wdata_i[BASIC_W-1:0]};
    ctrl_we   = wr_i && (addr_i == ADDR_W'(CTRL_ADDR));
    for (int i = 0; i < NCH; i++) begin
      we_clk[i]  = wr_i && (addr_i == ADDR_W'(2 * i));
      we_gate[i] = wr_i && (addr_i == ADDR_W'(2 * i + 1));
    end
  end

  always_comb begin
    csel_nxt = csel_q;
    gsel_nxt = gsel_q;
    enh_nxt  = enh_q;
    for (int i = 0; i < NCH; i++) begin
      if (we_clk[i])  csel_nxt[i] = store_val;
      if (we_gate[i]) gsel_nxt[i] = store_val;
    end
    if (ctrl_we) enh_nxt = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_q <= '0;
      gsel_q <= '0;
      enh_q  <= 1'b0;
    end else begin
      csel_q <= csel_nxt;
      gsel_q <= gsel_nxt;
      enh_q  <= enh_nxt;
    end
  end

  assign csel_o  = csel_q;
  assign gsel_o  = gsel_q;
  assign enh_o   = enh_q;
  assign rearm_o = ctrl_we && wdata_i[1];

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R9
    basic_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_clk[i] && !enh_q) |=> (csel_q[i][SEL_W-1:BASIC_W] == '0));
  end
endmodule

// File: rtl/cgr_chan_mux.sv
module cgr_chan_mux #(
  parameter int SEL_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enh_i,
  input  logic [SEL_W-1:0]             csel_i,
  input  logic [SEL_W-1:0]             gsel_i,
  input  logic [cgr_pkg::NUM_RATES:0]  tick_i,
  input  logic                         pin_rise_i,
  input  logic                         prev_rise_i,
  input  logic                         ext_rise_i,
  input  logic                         pat_rise_i,
  input  logic                         gat_pin_i,
  input  logic                         nm2_out_i,
  input  logic                         pat_i,
  input  logic                         occ_i,
  input  logic                         gone_i,
  output logic                         clk_en_o,
  output logic                         gate_o
);
  import cgr_pkg::*;

  localparam int BASIC_CLK_MAX  = 7;
  localparam int BASIC_GATE_MAX = 3;

  logic [31:0] cs, gs;
  logic        clk_nxt, gate_nxt;
  logic        clk_en_q, gate_q;

  always_comb begin
    cs = {{(32-SEL_W){1'b0}}, csel_i};
    clk_nxt = 1'b0;
    if (enh_i || cs <= BASIC_CLK_MAX) begin
      case (cs)
        CK_PIN:  clk_nxt = pin_rise_i;
        1:       clk_nxt = tick_i[1];
        2:       clk_nxt = tick_i[2];
        3:       clk_nxt = tick_i[3];
        4:       clk_nxt = tick_i[4];
        5:       clk_nxt = tick_i[5];
        CK_PREV: clk_nxt = prev_rise_i;
        CK_EXT:  clk_nxt = ext_rise_i;
        CK_HIGH: clk_nxt = 1'b0;
        CK_LOW:  clk_nxt = 1'b0;
        CK_PAT:  clk_nxt = pat_rise_i;
        CK_FAST: clk_nxt = tick_i[0];
        default: clk_nxt = 1'b0;
      endcase
    end
  end

  always_comb begin
    gs = {{(32-SEL_W){1'b0}}, gsel_i};
    gate_nxt = 1'b0;
    if (enh_i || gs <= BASIC_GATE_MAX) begin
      case (gs)
        GT_ON:       gate_nxt = 1'b1;
        GT_OFF:      gate_nxt = 1'b0;
        GT_PIN:      gate_nxt = gat_pin_i;
        GT_NM2_INV:  gate_nxt = ~nm2_out_i;
        GT_PIN_INV:  gate_nxt = ~gat_pin_i;
        GT_NM2:      gate_nxt = nm2_out_i;
        GT_PAT:      gate_nxt = pat_i;
        GT_OCC:      gate_nxt = occ_i;
        GT_GONE:     gate_nxt = gone_i;
        GT_PAT_INV:  gate_nxt = ~pat_i;
        GT_OCC_INV:  gate_nxt = ~occ_i;
        GT_GONE_INV: gate_nxt = ~gone_i;
        default:     gate_nxt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en_q <= 1'b0;
      gate_q   <= 1'b1;
    end else begin
      clk_en_q <= clk_nxt;
      gate_q   <= gate_nxt;
    end
  end

  assign clk_en_o = clk_en_q;
  assign gate_o   = gate_q;

  // R5
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gsel_i == SEL_W'(GT_OFF)) |=> !gate_o);
  // R5
  gate_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gsel_i == SEL_W'(GT_ON)) |=> gate_o);
  // R6
  const_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_i && (csel_i == SEL_W'(CK_HIGH) || csel_i == SEL_W'(CK_LOW))) |=> !clk_en_o);
endmodule

// File: rtl/ctr_clkgate_router.sv
module ctr_clkgate_router #(
  parameter int NUM_UNITS = 2,
  parameter int SEL_W     = 5,
  parameter int FIRST_DIV = 2,
  parameter int DECADE    = 10,
  parameter int NCH       = NUM_UNITS * cgr_pkg::CH_PER_UNIT,
  parameter int ADDR_W    = $clog2(2 * NCH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [SEL_W-1:0]     reg_wdata,
  input  logic [NCH-1:0]       clk_pin,
  input  logic [NCH-1:0]       gat_pin,
  input  logic [NUM_UNITS-1:0] ext_clk,
  input  logic [NCH-1:0]       cnt_out,
  input  logic                 pattern_present,
  output logic [NCH-1:0]       cnt_clk_en,
  output logic [NCH-1:0]       cnt_gate,
  output logic [NCH-1:0]       clk_pin_oe,
  output logic [NCH-1:0]       gat_pin_oe,
  output logic                 pat_occurred,
  output logic                 pat_gone
);
  import cgr_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // previous-sample registers for rising-edge detection
  logic [NCH-1:0]       clk_pin_d, cnt_out_d;
  logic [NUM_UNITS-1:0] ext_d;
  logic                 pat_d;
  logic [NCH-1:0]       pin_rise, out_rise;
  logic [NUM_UNITS-1:0] ext_rise;
  logic                 pat_rise;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      clk_pin_d <= '0;
      cnt_out_d <= '0;
      ext_d     <= '0;
      pat_d     <= 1'b0;
    end else begin
      clk_pin_d <= clk_pin;
      cnt_out_d <= cnt_out;
      ext_d     <= ext_clk;
      pat_d     <= pattern_present;
    end
  end

  always_comb begin
    pin_rise = clk_pin & ~clk_pin_d;
    out_rise = cnt_out & ~cnt_out_d;
    ext_rise = ext_clk & ~ext_d;
    pat_rise = pattern_present & ~pat_d;
  end

  logic [NCH-1:0][SEL_W-1:0] csel, gsel;
  logic                      enh, rearm;
  logic [NUM_RATES:0]        tick;
  logic                      occ, gone;

  cgr_sel_regs #(.NCH(NCH), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_i    (reg_wr),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .csel_o  (csel),
    .gsel_o  (gsel),
    .enh_o   (enh),
    .rearm_o (rearm)
  );

  cgr_tick_gen #(.FIRST_DIV(FIRST_DIV), .DECADE(DECADE)) u_ticks (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .tick_o (tick)
  );

  cgr_pattern_latch u_pat (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .pat_i   (pattern_present),
    .rearm_i (rearm),
    .occ_o   (occ),
    .gone_o  (gone)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    for (genvar c = 0; c < CH_PER_UNIT; c++) begin : g_ch
      localparam int G    = u * CH_PER_UNIT + c;
      localparam int PREV = prev_clk_idx(u, c, NUM_UNITS);
      localparam int NM2  = nm2_idx(u, c, NUM_UNITS);

      cgr_chan_mux #(.SEL_W(SEL_W)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n_i),
        .enh_i       (enh),
        .csel_i      (csel[G]),
        .gsel_i      (gsel[G]),
        .tick_i      (tick),
        .pin_rise_i  (pin_rise[G]),
        .prev_rise_i (out_rise[PREV]),
        .ext_rise_i  (ext_rise[u]),
        .pat_rise_i  (pat_rise),
        .gat_pin_i   (gat_pin[G]),
        .nm2_out_i   (cnt_out[NM2]),
        .pat_i       (pattern_present),
        .occ_i       (occ),
        .gone_i      (gone),
        .clk_en_o    (cnt_clk_en[G]),
        .gate_o      (cnt_gate[G])
      );

      assign clk_pin_oe[G] = (csel[G] != SEL_W'(CK_PIN));
      assign gat_pin_oe[G] = (gsel[G] != SEL_W'(GT_PIN));

      // R11
      clk_dir_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
        (reg_wr && reg_addr == ADDR_W'(2 * G) && reg_wdata == '0) |=> !clk_pin_oe[G]);
    end
  end

  assign pat_occurred = occ;
  assign pat_gone     = gone;
endmodule

// File: tb/sim_ctr_clkgate_router.sv
module sim_ctr_clkgate_router;
  localparam int NU  = 2;
  localparam int NCH = 6;
  localparam int AW  = 4;
  localparam int SW  = 5;
  localparam int CTRL = 12;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [SW-1:0]  reg_wdata = '0;
  logic [NCH-1:0] clk_pin = '0, gat_pin = '0, cnt_out = '0;
  logic [NU-1:0]  ext_clk = '0;
  logic           pattern_present = 1'b0;
  logic [NCH-1:0] cnt_clk_en, cnt_gate, clk_pin_oe, gat_pin_oe;
  logic           pat_occurred, pat_gone;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctr_clkgate_router u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .clk_pin(clk_pin), .gat_pin(gat_pin),
    .ext_clk(ext_clk), .cnt_out(cnt_out), .pattern_present(pattern_present),
    .cnt_clk_en(cnt_clk_en), .cnt_gate(cnt_gate), .clk_pin_oe(clk_pin_oe),
    .gat_pin_oe(gat_pin_oe), .pat_occurred(pat_occurred), .pat_gone(pat_gone)
  );

  // gate vectors: {channel, gate code, gate pins, counter outputs, expected gate}
  localparam int NV = 16;
  localparam logic [20:0] GVEC [NV] = '{
    {3'd0, 5'd0,  6'h00, 6'h00, 1'b1},
    {3'd0, 5'd1,  6'h3F, 6'h3F, 1'b0},
    {3'd2, 5'd2,  6'h04, 6'h00, 1'b1},
    {3'd2, 5'd2,  6'h3B, 6'h00, 1'b0},
    {3'd0, 5'd3,  6'h00, 6'h10, 1'b0},
    {3'd0, 5'd3,  6'h00, 6'h2F, 1'b1},
    {3'd1, 5'd7,  6'h00, 6'h20, 1'b1},
    {3'd1, 5'd7,  6'h00, 6'h1F, 1'b0},
    {3'd2, 5'd7,  6'h00, 6'h01, 1'b1},
    {3'd3, 5'd7,  6'h00, 6'h02, 1'b1},
    {3'd4, 5'd3,  6'h00, 6'h04, 1'b0},
    {3'd5, 5'd7,  6'h00, 6'h08, 1'b1},
    {3'd5, 5'd6,  6'h20, 6'h00, 1'b0},
    {3'd5, 5'd6,  6'h00, 6'h00, 1'b1},
    {3'd3, 5'd4,  6'h3F, 6'h3F, 1'b0},
    {3'd3, 5'd20, 6'h3F, 6'h3F, 1'b0}
  };

  localparam int PREV [NCH] = '{5, 0, 1, 2, 3, 4};
  localparam int RATE_CODE [6] = '{1, 2, 3, 4, 5, 11};
  localparam int RATE_IV   [6] = '{2, 20, 200, 2000, 20000, 1};

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = SW'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic measure(input int ch, output int iv);
    int n;
    n = 0;
    while (!cnt_clk_en[ch] && n < 50000) begin @(negedge clk); n++; end
    @(negedge clk);
    iv = 1;
    while (!cnt_clk_en[ch] && iv < 50000) begin @(negedge clk); iv++; end
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int iv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(cnt_gate, 6'h3F, "R1 gates");
    chk(cnt_clk_en, 0, "R1 clock enables");
    chk(clk_pin_oe, 0, "R1 clock pin direction");
    chk(gat_pin_oe, 6'h3F, "R1 gate pin direction");
    chk(pat_occurred, 0, "R1 occurred");
    chk(pat_gone, 1, "R1 gone-away");

    // R2 own clock pin, code 0 from reset
    @(negedge clk); clk_pin[0] = 1'b1;
    @(negedge clk); chk(cnt_clk_en[0], 1, "R2 pin pulse");
    @(negedge clk); chk(cnt_clk_en[0], 0, "R2 pin pulse width");
    clk_pin[0] = 1'b0;

    wr(CTRL, 1);
    // R2 external clock per unit
    wr(8, 7);
    @(negedge clk); ext_clk[0] = 1'b1;
    @(negedge clk); chk(cnt_clk_en[4], 0, "R2 other unit ext clock");
    ext_clk[0] = 1'b0; ext_clk[1] = 1'b1;
    @(negedge clk); chk(cnt_clk_en[4], 1, "R2 own unit ext clock");
    @(negedge clk); chk(cnt_clk_en[4], 0, "R2 ext pulse width");
    ext_clk[1] = 1'b0;

    // R4 preceding-output ring
    for (int g = 0; g < NCH; g++) begin
      wr(2 * g, 6);
      @(negedge clk); cnt_out[PREV[g]] = 1'b1;
      @(negedge clk); chk(cnt_clk_en[g], 1, "R4 preceding output pulse");
      @(negedge clk); chk(cnt_clk_en[g], 0, "R4 pulse width");
      cnt_out = '0;
    end

    // R5 R6 R10 gate vector table
    for (int v = 0; v < NV; v++) begin
      gat_pin = GVEC[v][12:7];
      cnt_out = GVEC[v][6:1];
      wr(2 * int'(GVEC[v][20:18]) + 1, int'(GVEC[v][17:13]));
      @(negedge clk);
      chk(cnt_gate[GVEC[v][20:18]], GVEC[v][0], "R5/R6/R10 gate routing vector");
    end
    gat_pin = '0; cnt_out = '0;

    // R6 constant clock codes and pattern rising edge
    wr(2, 8);
    @(negedge clk); clk_pin[1] = 1'b1;
    repeat (2) @(negedge clk);
    chk(cnt_clk_en[1], 0, "R6 constant high gives no enable");
    clk_pin[1] = 1'b0;
    wr(2, 9);
    repeat (2) @(negedge clk);
    chk(cnt_clk_en[1], 0, "R6 constant low gives no enable");
    wr(2, 10);
    @(negedge clk); pattern_present = 1'b1;
    @(negedge clk); chk(cnt_clk_en[1], 1, "R6 pattern edge pulse");
    @(negedge clk); chk(cnt_clk_en[1], 0, "R6 pattern pulse width");
    pattern_present = 1'b0;
    wr(2, 12);
    repeat (3) @(negedge clk);
    chk(cnt_clk_en[1], 0, "R10 reserved clock code");

    // R3 internal rates
    for (int k = 0; k < 6; k++) begin
      wr(0, RATE_CODE[k]);
      repeat (2) @(negedge clk);
      measure(0, iv);
      chk(iv, RATE_IV[k], "R3 rate interval");
    end

    // R7 R8 pattern latches
    pattern_present = 1'b0;
    wr(CTRL, 3);
    @(negedge clk);
    chk(pat_occurred, 0, "R8 re-arm occurred");
    chk(pat_gone, 1, "R8 re-arm gone-away");
    wr(1, 9); wr(3, 10); wr(5, 8); wr(7, 12); wr(9, 13); wr(11, 11);
    @(negedge clk);
    chk(cnt_gate, 6'b101010, "R7 idle pattern gates");
    pattern_present = 1'b1;
    repeat (2) @(negedge clk);
    chk(cnt_gate, 6'b000111, "R7 pattern present");
    pattern_present = 1'b0;
    repeat (2) @(negedge clk);
    chk(cnt_gate, 6'b110001, "R7 pattern gone");
    pattern_present = 1'b1;
    repeat (2) @(negedge clk);
    chk(cnt_gate[1:0], 2'b01, "R7 latches hold");
    pattern_present = 1'b0;
    wr(CTRL, 3);
    @(negedge clk);
    chk(cnt_gate[1:0], 2'b10, "R8 re-armed gates");

    // R9 basic mode masking
    wr(CTRL, 0);
    wr(0, 9);
    repeat (2) @(negedge clk);
    measure(0, iv);
    chk(iv, 2, "R9 masked clock code");
    wr(3, 8);
    @(negedge clk);
    chk(cnt_gate[1], 1, "R9 masked gate code");
    gat_pin[2] = 1'b0;
    wr(5, 6);
    @(negedge clk);
    chk(cnt_gate[2], 0, "R10 basic mode reserved gate");
    wr(CTRL, 1);
    @(negedge clk);
    chk(cnt_gate[2], 1, "R6 inverted pin in enhanced mode");

    // R12 unused addresses
    for (int a = 13; a < 16; a++) wr(a, 0);
    @(negedge clk);
    chk(cnt_gate[2], 1, "R12 unused address ignored");

    // R11 pin directions
    wr(6, 1);
    chk(clk_pin_oe[3], 1, "R11 clock pin output");
    wr(7, 2);
    chk(gat_pin_oe[3], 0, "R11 gate pin input");
    wr(6, 0);
    chk(clk_pin_oe[3], 0, "R11 clock pin input");
    wr(7, 0);
    chk(gat_pin_oe[3], 1, "R11 gate pin output");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule